// File: doc/BRIEF.md
# AT Bus Address Buffer

This block couples a 24-bit processor address bus to an AT-style expansion bus. On every clock edge at which the address-latch-enable strobe is high, it loads the processor address and byte-high enable into a register. It holds that value at every edge at which the strobe is low. The low 20 bits of the register drive the expansion address lines. Line 20 is driven separately, through a gate that can force it low. This lets software make the bus wrap at 1 MB.

The block also produces the two low-memory strobes, one for read and one for write, both active low. Each one follows its general memory strobe only when the latched address falls in the first megabyte. When an external bus master pulls its request line low, every expansion-side driver is switched off one edge later. Each driver group has its own output-enable signal, which a pad ring uses for the tri-state buffer.

Top module: `at_addr_buffer`

## Requirements
- R1: While reset is low, exp_addr is 0, exp_la20 is 0, exp_bhe_n, smem_rd_n and smem_wr_n are 1, and all four output enables are 0.
- R2: At a rising clock edge with ale high, cpu_addr[19:0] appears on exp_addr after that edge.
- R3: At a rising clock edge with ale low, exp_addr and exp_bhe_n keep their values, whatever cpu_addr and cpu_bhe_n do.
- R4: exp_la20 is 1 only when the latched cpu_addr[20] is 1 and a20_gate was 1 at the previous edge. A low a20_gate forces exp_la20 to 0 after the next edge.
- R5: exp_bhe_n is cpu_bhe_n, captured and held under the same ale rule as the address. It is active low.
- R6: smem_rd_n goes 0 after an edge at which mem_rd_n is 0 and the latched address is in the low 1 MB. Otherwise it is 1 after that edge.
- R7: smem_wr_n follows the rule of R6, using mem_wr_n in place of mem_rd_n.
- R8: The latched address lies in the low 1 MB when its bits 23..21 are all 0 and the gated bit 20 is 0. So with the gate off, an address of 0x100000 counts as low memory. With the gate on, it does not.
- R9: After an edge with master_n at 0, exp_addr_oe, exp_la20_oe, exp_bhe_oe and smem_oe are all 0. After an edge with master_n at 1, they are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_addr | input | 24 | Processor address bus |
| cpu_bhe_n | input | 1 | Processor byte-high enable, active low |
| ale | input | 1 | Address-latch-enable strobe, loads at edges while high |
| a20_gate | input | 1 | Enables address line 20 when 1 |
| mem_rd_n | input | 1 | Memory read strobe, active low |
| mem_wr_n | input | 1 | Memory write strobe, active low |
| master_n | input | 1 | External bus master request, active low |
| exp_addr | output | 20 | Latched expansion address lines 19..0 |
| exp_addr_oe | output | 1 | Driver enable for exp_addr |
| exp_la20 | output | 1 | Gated expansion address line 20 |
| exp_la20_oe | output | 1 | Driver enable for exp_la20 |
| exp_bhe_n | output | 1 | Latched byte-high enable, active low |
| exp_bhe_oe | output | 1 | Driver enable for exp_bhe_n |
| smem_rd_n | output | 1 | Low-memory read strobe, active low |
| smem_wr_n | output | 1 | Low-memory write strobe, active low |
| smem_oe | output | 1 | Driver enable for both low-memory strobes |

## Verification
Address, byte-high enable, gate and driver enables are each due one rising edge after the input that sets them. The bench changes inputs on the falling edge and reads results on the next falling edge.

The low-memory strobes are due one edge after mem_rd_n or mem_wr_n changes. They are decided on the address and gate already held before that edge. So a scenario first latches its address, waits one edge, and only then drops the strobe. When the gate changes, the bench waits two edges before it expects the strobe to reflect the new region.

// File: rtl/abuf_pkg.sv
`timescale 1ns/1ps
package abuf_pkg;
    parameter int CPU_AW   = 24;
    parameter int EXP_AW   = 20;
    parameter int N_STROBE = 2;

    typedef struct packed {
        logic [CPU_AW-1:0] addr;
        logic              bhe_n;
    } latch_t;

    typedef struct packed {
        logic [N_STROBE-1:0] strb_n;
    } lowmem_t;

    typedef struct packed {
        logic addr_oe;
        logic la20_oe;
        logic bhe_oe;
        logic smem_oe;
    } drive_t;
endpackage

// File: rtl/abuf_latch.sv
`timescale 1ns/1ps
module abuf_latch
    import abuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              cpu_bhe_n,
    output logic [CPU_AW-1:0] addr_q,
    output logic              bhe_n_q
);
    latch_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ale) begin
            st_d.addr  = cpu_addr;
            st_d.bhe_n = cpu_bhe_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.addr  <= '0;
            st_q.bhe_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_q  = st_q.addr;
    assign bhe_n_q = st_q.bhe_n;

    assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> (addr_q == $past(cpu_addr)));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ale |=> ($stable(addr_q) && $stable(bhe_n_q)));

    assert_bhe_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> (bhe_n_q == $past(cpu_bhe_n)));
endmodule

// File: rtl/abuf_a20.sv
`timescale 1ns/1ps
module abuf_a20 (
    input  logic clk,
    input  logic rst_n,
    input  logic a20_gate,
    input  logic addr_a20,
    output logic gate_q,
    output logic la20
);
    logic gate_d, gate_r;

    always_comb begin
        gate_d = a20_gate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gate_r <= 1'b0;
        else        gate_r <= gate_d;
    end

    assign gate_q = gate_r;
    assign la20   = addr_a20 & gate_r;

    assert_gate_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !a20_gate |=> !la20);
endmodule

// File: rtl/abuf_lowmem.sv
`timescale 1ns/1ps
module abuf_lowmem
    import abuf_pkg::*;
#(
    parameter int HI_W = CPU_AW - EXP_AW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [HI_W-1:0]     addr_hi,
    input  logic                gate_q,
    input  logic [N_STROBE-1:0] mem_n,
    output logic [N_STROBE-1:0] smem_n
);
    lowmem_t             st_d, st_q;
    logic                in_low;
    logic [N_STROBE-1:0] hit_n;

    assign in_low = ~(|addr_hi[HI_W-1:1]) & ~(addr_hi[0] & gate_q);

    for (genvar g = 0; g < N_STROBE; g++) begin : g_strobe
        assign hit_n[g] = mem_n[g] | ~in_low;
    end

    always_comb begin
        st_d        = st_q;
        st_d.strb_n = hit_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.strb_n <= '1;
        else        st_q <= st_d;
    end

    assign smem_n = st_q.strb_n;

    // index 0 carries the read strobe
    assert_rd_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_n[0] |=> smem_n[0]);

    // index N_STROBE-1 carries the write strobe
    assert_wr_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_n[N_STROBE-1] |=> smem_n[N_STROBE-1]);

    assert_high_region_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|addr_hi[HI_W-1:1]) |=> (smem_n == '1));
endmodule

// File: rtl/abuf_drive.sv
`timescale 1ns/1ps
module abuf_drive
    import abuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic master_n,
    output logic addr_oe,
    output logic la20_oe,
    output logic bhe_oe,
    output logic smem_oe
);
    drive_t st_d, st_q;

    always_comb begin
        st_d.addr_oe = master_n;
        st_d.la20_oe = master_n;
        st_d.bhe_oe  = master_n;
        st_d.smem_oe = master_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_oe = st_q.addr_oe;
    assign la20_oe = st_q.la20_oe;
    assign bhe_oe  = st_q.bhe_oe;
    assign smem_oe = st_q.smem_oe;

    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !master_n |=> !(addr_oe | la20_oe | bhe_oe | smem_oe));

    assert_restore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        master_n |=> (addr_oe & la20_oe & bhe_oe & smem_oe));
endmodule

// File: rtl/at_addr_buffer.sv
`timescale 1ns/1ps
module at_addr_buffer
    import abuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              cpu_bhe_n,
    input  logic              ale,
    input  logic              a20_gate,
    input  logic              mem_rd_n,
    input  logic              mem_wr_n,
    input  logic              master_n,
    output logic [EXP_AW-1:0] exp_addr,
    output logic              exp_addr_oe,
    output logic              exp_la20,
    output logic              exp_la20_oe,
    output logic              exp_bhe_n,
    output logic              exp_bhe_oe,
    output logic              smem_rd_n,
    output logic              smem_wr_n,
    output logic              smem_oe
);
    localparam int HI_W = CPU_AW - EXP_AW;

    logic [CPU_AW-1:0]   addr_q;
    logic                bhe_n_q;
    logic                gate_q;
    logic [N_STROBE-1:0] mem_n;
    logic [N_STROBE-1:0] smem_n;

    abuf_latch u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .ale       (ale),
        .cpu_addr  (cpu_addr),
        .cpu_bhe_n (cpu_bhe_n),
        .addr_q    (addr_q),
        .bhe_n_q   (bhe_n_q)
    );

    abuf_a20 u_a20 (
        .clk      (clk),
        .rst_n    (rst_n),
        .a20_gate (a20_gate),
        .addr_a20 (addr_q[EXP_AW]),
        .gate_q   (gate_q),
        .la20     (exp_la20)
    );

    assign mem_n[0]          = mem_rd_n;
    assign mem_n[N_STROBE-1] = mem_wr_n;

    abuf_lowmem #(.HI_W(HI_W)) u_lowmem (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_hi (addr_q[CPU_AW-1:EXP_AW]),
        .gate_q  (gate_q),
        .mem_n   (mem_n),
        .smem_n  (smem_n)
    );

    abuf_drive u_drive (
        .clk      (clk),
        .rst_n    (rst_n),
        .master_n (master_n),
        .addr_oe  (exp_addr_oe),
        .la20_oe  (exp_la20_oe),
        .bhe_oe   (exp_bhe_oe),
        .smem_oe  (smem_oe)
    );

    assign exp_addr  = addr_q[EXP_AW-1:0];
    assign exp_bhe_n = bhe_n_q;
    assign smem_rd_n = smem_n[0];
    assign smem_wr_n = smem_n[N_STROBE-1];
endmodule

// File: tb/at_addr_buffer_bench.sv
`timescale 1ns/1ps
module at_addr_buffer_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [23:0] cpu_addr;
    logic        cpu_bhe_n, ale, a20_gate, mem_rd_n, mem_wr_n, master_n;
    logic [19:0] exp_addr;
    logic        exp_addr_oe, exp_la20, exp_la20_oe, exp_bhe_n, exp_bhe_oe;
    logic        smem_rd_n, smem_wr_n, smem_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    at_addr_buffer u_at_addr_buffer (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_bhe_n(cpu_bhe_n),
        .ale(ale), .a20_gate(a20_gate), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
        .master_n(master_n), .exp_addr(exp_addr), .exp_addr_oe(exp_addr_oe),
        .exp_la20(exp_la20), .exp_la20_oe(exp_la20_oe), .exp_bhe_n(exp_bhe_n),
        .exp_bhe_oe(exp_bhe_oe), .smem_rd_n(smem_rd_n), .smem_wr_n(smem_wr_n),
        .smem_oe(smem_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic latch_addr(input logic [23:0] a);
        cpu_addr = a;
        ale      = 1'b1;
        step();
        ale      = 1'b0;
    endtask

    task automatic test_reset();
        chk("R1 addr", {12'b0, exp_addr}, 32'h0);
        chk("R1 la20", {31'b0, exp_la20}, 32'h0);
        chk("R1 strobes", {29'b0, exp_bhe_n, smem_rd_n, smem_wr_n}, 32'h7);
        chk("R1 enables", {28'b0, exp_addr_oe, exp_la20_oe, exp_bhe_oe, smem_oe}, 32'h0);
    endtask

    task automatic test_capture_hold();
        latch_addr(24'h0ABCDE);
        chk("R2 capture", {12'b0, exp_addr}, 32'hABCDE);
        latch_addr(24'h012345);
        chk("R2 second capture", {12'b0, exp_addr}, 32'h12345);
        cpu_addr = 24'h0FFFFF;
        step();
        chk("R3 hold", {12'b0, exp_addr}, 32'h12345);
        cpu_addr = 24'h000001;
        step();
        chk("R3 hold again", {12'b0, exp_addr}, 32'h12345);
    endtask

    task automatic test_bhe();
        cpu_bhe_n = 1'b0;
        latch_addr(24'h000010);
        chk("R5 bhe low", {31'b0, exp_bhe_n}, 32'h0);
        cpu_bhe_n = 1'b1;
        step();
        chk("R5 bhe held", {31'b0, exp_bhe_n}, 32'h0);
        latch_addr(24'h000010);
        chk("R5 bhe high", {31'b0, exp_bhe_n}, 32'h1);
    endtask

    task automatic test_a20();
        a20_gate = 1'b1;
        latch_addr(24'h100000);
        chk("R4 gate on", {31'b0, exp_la20}, 32'h1);
        a20_gate = 1'b0;
        step();
        chk("R4 gate off", {31'b0, exp_la20}, 32'h0);
        chk("R4 addr low bits", {12'b0, exp_addr}, 32'h0);
    endtask

    task automatic test_read();
        latch_addr(24'h0F0000);
        mem_rd_n = 1'b0;
        step();
        chk("R6 read low", {30'b0, smem_rd_n, smem_wr_n}, 32'h1);
        mem_rd_n = 1'b1;
        step();
        chk("R6 read release", {31'b0, smem_rd_n}, 32'h1);
        latch_addr(24'h200000);
        mem_rd_n = 1'b0;
        step();
        chk("R6 read above 1MB", {31'b0, smem_rd_n}, 32'h1);
        mem_rd_n = 1'b1;
        step();
    endtask

    task automatic test_write();
        latch_addr(24'h00ABCD);
        mem_wr_n = 1'b0;
        step();
        chk("R7 write low", {30'b0, smem_rd_n, smem_wr_n}, 32'h2);
        mem_wr_n = 1'b1;
        step();
        chk("R7 write release", {31'b0, smem_wr_n}, 32'h1);
        latch_addr(24'hE00000);
        mem_wr_n = 1'b0;
        step();
        chk("R7 write above 1MB", {31'b0, smem_wr_n}, 32'h1);
        mem_wr_n = 1'b1;
        step();
    endtask

    task automatic test_wrap();
        a20_gate = 1'b0;
        latch_addr(24'h100000);
        mem_rd_n = 1'b0;
        step();
        chk("R8 wrap counts low", {31'b0, smem_rd_n}, 32'h0);
        a20_gate = 1'b1;
        step();
        step();
        chk("R8 gate on leaves low 1MB", {31'b0, smem_rd_n}, 32'h1);
        mem_rd_n = 1'b1;
        a20_gate = 1'b0;
        step();
    endtask

    task automatic test_master();
        master_n = 1'b0;
        step();
        chk("R9 release", {28'b0, exp_addr_oe, exp_la20_oe, exp_bhe_oe, smem_oe}, 32'h0);
        step();
        chk("R9 stay released", {28'b0, exp_addr_oe, exp_la20_oe, exp_bhe_oe, smem_oe}, 32'h0);
        master_n = 1'b1;
        step();
        chk("R9 restore", {28'b0, exp_addr_oe, exp_la20_oe, exp_bhe_oe, smem_oe}, 32'hF);
    endtask

    initial begin
        rst_n = 1'b0; cpu_addr = 24'h0; cpu_bhe_n = 1'b1; ale = 1'b0;
        a20_gate = 1'b0; mem_rd_n = 1'b1; mem_wr_n = 1'b1; master_n = 1'b1;
        step();
        step();
        test_reset();
        rst_n = 1'b1;
        step();
        chk("R9 on after reset", {28'b0, exp_addr_oe, exp_la20_oe, exp_bhe_oe, smem_oe}, 32'hF);
        test_capture_hold();
        test_bhe();
        test_a20();
        test_read();
        test_write();
        test_wrap();
        test_master();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule